// File: doc/BRIEF.md
# I2C Serial Memory Slave

This block is the bus-side controller of an 8192-byte serial memory that answers as a slave on a two-wire I2C bus. It receives the bus clock and data lines as plain inputs sampled by the system clock. It synchronizes both lines, finds START and STOP conditions, and pulls the data line low through a single open-drain enable output. The first byte after a START carries a device-type code, three chip-enable bits compared against strap inputs, and a read/write flag. A write goes on with a two-byte word address, high byte first, followed by data bytes. A read returns bytes from an internal address pointer that advances after every byte sent.

Data bytes of a write are collected in a 32-byte page buffer. The memory array changes only when a STOP closes the write. That STOP starts a self-timed programming period of `WRITE_CYCLES` clocks. During this period the controller copies the buffered bytes into the array and ignores all bus activity. A write-lock input refuses data bytes, so no programming period starts. Reads come in three forms: from the current pointer, at a chosen address (an address-only write followed by a repeated START), and sequential, where every master ACK asks for the next byte.

Top module: `ee_i2c_slave`

## Requirements
- R1: In reset and right after it, `sda_oe` is 0 and the controller waits for a START.
- R2: A START (SDA falls while SCL is high) or a STOP (SDA rises while SCL is high) is detected in any state except the programming period. Data is sampled on SCL rising edges. The controller changes `sda_oe` only while SCL is low. An ACK is `sda_oe`=1 for the whole of the 9th clock.
- R3: The first byte after START has bits [7:4] equal to `DEV_TYPE` (default 4'b1010), bits [3:1] equal to `chip_en`, and bit [0] set to 1 for read and 0 for write. On a match it is acknowledged. On a mismatch it is not, and the controller stays silent until the next START.
- R4: A write select is followed by two acknowledged address bytes, high byte first. Only the low 13 bits of the 16 received bits form the word address.
- R5: Each accepted data byte is acknowledged and stored at the page offset given by the low 5 address bits. The offset then advances and wraps within the 32-byte page. A 33rd or later byte overwrites the slot it wraps onto.
- R6: A STOP after at least one accepted data byte starts a programming period of `WRITE_CYCLES` clocks. During it no byte is acknowledged and START is ignored. Afterwards every buffered byte is in the array and nothing else has changed.
- R7: While `wr_lock` is 1, a data byte is not acknowledged and is not buffered. The controller stays silent until the next START, and the closing STOP starts no programming period.
- R8: A STOP after only the address bytes of a write starts no programming period. The loaded address becomes the current read address.
- R9: A read select reads from the current pointer. After an address-only write, a repeated START then reads from that address.
- R10: A sequential read sends bytes from consecutive addresses while the master ACKs each one. After a master NACK the controller releases the bus. The pointer rolls over from 8191 to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| chip_en | input | 3 | Strap value compared with bits [3:1] of the select byte |
| wr_lock | input | 1 | When 1, data bytes of writes are refused |
| sda_oe | output | 1 | 1 pulls the data line low; 0 releases it |

## Verification
Writes are tried as a single byte, as a 34-byte burst that starts two bytes before a page end, and as an address-only command. These show apart the commit-on-STOP path, the in-page wrap with overwrite, and the no-programming case. Reads are made from the current pointer, at a random address through a repeated START, and as a sequential burst crossing the top address. These separate pointer loading from auto-increment and rollover. Select bytes with a wrong chip-enable or a wrong type code, data sent with the lock raised, and a select sent during the programming period all check that the controller answers with silence exactly where it must.

// File: rtl/ee_slave_pkg.sv
package ee_slave_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEVSEL,
        ST_ACK_DEV,
        ST_ADDR_HI,
        ST_ACK_HI,
        ST_ADDR_LO,
        ST_ACK_LO,
        ST_WDATA,
        ST_ACK_WD,
        ST_RDATA,
        ST_RACK,
        ST_BUSY
    } ctl_state_e;

    // Events derived from the synchronized bus lines
    typedef struct packed {
        logic scl;       // synchronized clock level
        logic sda;       // synchronized data level
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_evt_t;

    // Select byte layout: [7:4] type code, [3:1] chip enable, [0] read flag
    function automatic logic select_hit(input logic [7:0] sel,
                                        input logic [3:0] kind,
                                        input logic [2:0] ce);
        return (sel[7:4] == kind) && (sel[3:1] == ce);
    endfunction

    function automatic logic is_rx_state(input ctl_state_e s);
        return (s == ST_DEVSEL) || (s == ST_ADDR_HI) ||
               (s == ST_ADDR_LO) || (s == ST_WDATA);
    endfunction

endpackage

// File: rtl/ee_bus_sync.sv
module ee_bus_sync
    import ee_slave_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt
);
    localparam int SH_W = SYNC_STAGES + 1;

    logic [SH_W-1:0] scl_sh;
    logic [SH_W-1:0] sda_sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sh <= '1;
            sda_sh <= '1;
        end else begin
            scl_sh <= {scl_sh[SH_W-2:0], scl_i};
            sda_sh <= {sda_sh[SH_W-2:0], sda_i};
        end
    end

    logic scl_now, scl_old, sda_now, sda_old;
    assign scl_now = scl_sh[SYNC_STAGES-1];
    assign scl_old = scl_sh[SYNC_STAGES];
    assign sda_now = sda_sh[SYNC_STAGES-1];
    assign sda_old = sda_sh[SYNC_STAGES];

    always_comb begin
        evt.scl      = scl_now;
        evt.sda      = sda_now;
        evt.scl_rise = scl_now & ~scl_old;
        evt.scl_fall = ~scl_now & scl_old;
        evt.start    = scl_now & scl_old & sda_old & ~sda_now;
        evt.stop     = scl_now & scl_old & ~sda_old & sda_now;
    end

endmodule

// File: rtl/ee_page_buf.sv
module ee_page_buf #(
    parameter int PAGE_BYTES = 32,
    parameter int DATA_W     = 8,
    localparam int OFS_W     = $clog2(PAGE_BYTES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [OFS_W-1:0]  wr_ofs,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [OFS_W-1:0]  rd_ofs,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    logic [DATA_W-1:0]     slot [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] filled;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            filled <= '0;
        end else if (wr_en) begin
            filled[wr_ofs] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            slot[wr_ofs] <= wr_data;
        end
    end

    assign rd_data  = slot[rd_ofs];
    assign rd_valid = filled[rd_ofs];

endmodule

// File: rtl/ee_mem_array.sv
module ee_mem_array #(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/ee_i2c_slave.sv
module ee_i2c_slave
    import ee_slave_pkg::*;
#(
    parameter logic [3:0] DEV_TYPE     = 4'b1010,
    parameter int         ADDR_W       = 13,
    parameter int         PAGE_BYTES   = 32,
    parameter int         WRITE_CYCLES = 2000,
    parameter int         SYNC_STAGES  = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] chip_en,
    input  logic       wr_lock,
    output logic       sda_oe
);
    localparam int OFS_W = $clog2(PAGE_BYTES);
    localparam int HI_W  = ADDR_W - 8;
    localparam int CNT_W = $clog2(WRITE_CYCLES + 1);
    localparam logic [CNT_W-1:0] BUSY_LAST = CNT_W'(WRITE_CYCLES - 1);
    localparam logic [CNT_W-1:0] PAGE_CNT  = CNT_W'(PAGE_BYTES);

    bus_evt_t ev;

    ee_bus_sync #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .evt   (ev)
    );

    ctl_state_e        state;
    logic [7:0]        shreg;
    logic [3:0]        bit_cnt;
    logic              rw_q;
    logic [HI_W-1:0]   hi_q;
    logic [ADDR_W-1:0] addr_q;
    logic [7:0]        tx_q;
    logic              oe_q;
    logic              mack_q;
    logic              wr_pending;
    logic [CNT_W-1:0]  busy_cnt;

    logic              byte_done;
    logic              buf_we;
    logic              buf_clr;
    logic              busy_done;
    logic              commit_on;
    logic [7:0]        buf_rd;
    logic              buf_vld;
    logic [7:0]        mem_rd;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr;

    always_comb begin
        byte_done = ev.scl_fall && (bit_cnt == 4'd8);
        buf_we    = (state == ST_WDATA) && byte_done && !wr_lock;
        busy_done = (state == ST_BUSY) && (busy_cnt == BUSY_LAST);
        buf_clr   = busy_done || ((state != ST_BUSY) && ev.start);
        commit_on = (state == ST_BUSY) && (busy_cnt < PAGE_CNT);
        mem_we    = commit_on && buf_vld;
        mem_waddr = {addr_q[ADDR_W-1:OFS_W], busy_cnt[OFS_W-1:0]};
    end

    ee_page_buf #(.PAGE_BYTES(PAGE_BYTES), .DATA_W(8)) page_i (
        .clk      (clk),
        .rst      (rst),
        .clr      (buf_clr),
        .wr_en    (buf_we),
        .wr_ofs   (addr_q[OFS_W-1:0]),
        .wr_data  (shreg),
        .rd_ofs   (busy_cnt[OFS_W-1:0]),
        .rd_data  (buf_rd),
        .rd_valid (buf_vld)
    );

    ee_mem_array #(.ADDR_W(ADDR_W), .DATA_W(8)) mem_i (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (buf_rd),
        .raddr (addr_q),
        .rdata (mem_rd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            shreg      <= '0;
            bit_cnt    <= '0;
            rw_q       <= 1'b0;
            hi_q       <= '0;
            addr_q     <= '0;
            tx_q       <= '0;
            oe_q       <= 1'b0;
            mack_q     <= 1'b0;
            wr_pending <= 1'b0;
            busy_cnt   <= '0;
        end else if (state == ST_BUSY) begin
            if (busy_done) begin
                state      <= ST_IDLE;
                busy_cnt   <= '0;
                wr_pending <= 1'b0;
            end else begin
                busy_cnt <= busy_cnt + 1'b1;
            end
        end else if (ev.start) begin
            state      <= ST_DEVSEL;
            bit_cnt    <= '0;
            oe_q       <= 1'b0;
            wr_pending <= 1'b0;
        end else if (ev.stop) begin
            oe_q     <= 1'b0;
            bit_cnt  <= '0;
            busy_cnt <= '0;
            state    <= wr_pending ? ST_BUSY : ST_IDLE;
        end else begin
            if (is_rx_state(state) && ev.scl_rise && (bit_cnt != 4'd8)) begin
                shreg   <= {shreg[6:0], ev.sda};
                bit_cnt <= bit_cnt + 1'b1;
            end
            case (state)
                ST_DEVSEL: if (byte_done) begin
                    bit_cnt <= '0;
                    if (select_hit(shreg, DEV_TYPE, chip_en)) begin
                        rw_q  <= shreg[0];
                        oe_q  <= 1'b1;
                        state <= ST_ACK_DEV;
                    end else begin
                        state <= ST_IDLE;
                    end
                end
                ST_ADDR_HI: if (byte_done) begin
                    bit_cnt <= '0;
                    hi_q    <= shreg[HI_W-1:0];
                    oe_q    <= 1'b1;
                    state   <= ST_ACK_HI;
                end
                ST_ADDR_LO: if (byte_done) begin
                    bit_cnt <= '0;
                    addr_q  <= {hi_q, shreg};
                    oe_q    <= 1'b1;
                    state   <= ST_ACK_LO;
                end
                ST_WDATA: if (byte_done) begin
                    bit_cnt <= '0;
                    if (!wr_lock) begin
                        addr_q[OFS_W-1:0] <= addr_q[OFS_W-1:0] + 1'b1;
                        wr_pending        <= 1'b1;
                        oe_q              <= 1'b1;
                        state             <= ST_ACK_WD;
                    end else begin
                        state <= ST_IDLE;
                    end
                end
                ST_ACK_DEV: if (ev.scl_fall) begin
                    if (rw_q) begin
                        tx_q    <= mem_rd;
                        oe_q    <= ~mem_rd[7];
                        addr_q  <= addr_q + 1'b1;
                        bit_cnt <= '0;
                        state   <= ST_RDATA;
                    end else begin
                        oe_q  <= 1'b0;
                        state <= ST_ADDR_HI;
                    end
                end
                ST_ACK_HI: if (ev.scl_fall) begin
                    oe_q  <= 1'b0;
                    state <= ST_ADDR_LO;
                end
                ST_ACK_LO, ST_ACK_WD: if (ev.scl_fall) begin
                    oe_q  <= 1'b0;
                    state <= ST_WDATA;
                end
                ST_RDATA: if (ev.scl_fall) begin
                    if (bit_cnt == 4'd7) begin
                        oe_q  <= 1'b0;
                        state <= ST_RACK;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                        tx_q    <= {tx_q[6:0], tx_q[7]};
                        oe_q    <= ~tx_q[6];
                    end
                end
                ST_RACK: begin
                    if (ev.scl_rise) begin
                        mack_q <= ~ev.sda;
                    end
                    if (ev.scl_fall) begin
                        if (mack_q) begin
                            tx_q    <= mem_rd;
                            oe_q    <= ~mem_rd[7];
                            addr_q  <= addr_q + 1'b1;
                            bit_cnt <= '0;
                            state   <= ST_RDATA;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assign sda_oe = oe_q;

    // R2: the line is only ever pulled low while the clock is low
    p_pull_on_low_scl_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !ev.scl);

    // R6: silent for the whole programming period
    p_quiet_busy_r6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_BUSY) |-> !sda_oe);

    // R6: a programming period only ever follows a STOP
    p_busy_after_stop_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(state == ST_BUSY) |-> $past(ev.stop));

    // R7: a data byte is acknowledged only when the lock was low
    p_lock_refuses_r7: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_ACK_WD) && ($past(state) == ST_WDATA)) |-> !$past(wr_lock));

    // R10: every byte sent moves the pointer forward by one, wrapping at the top
    p_read_step_r10: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_RDATA) && ($past(state) != ST_RDATA)) |->
            (addr_q == ($past(addr_q) + 1'b1)));

endmodule

// File: tb/ee_i2c_slave_tb.sv
module ee_i2c_slave_tb_top;

    localparam int         WC   = 300;
    localparam int         H    = 5;
    localparam logic [3:0] DEVT = 4'b1010;
    localparam logic [2:0] CE   = 3'b101;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [2:0] chip_en = CE;
    logic       wr_lock = 1'b0;
    logic       sda_oe;
    logic       sda_line;

    always #10 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    ee_i2c_slave #(.WRITE_CYCLES(WC)) dut_i (
        .clk     (clk),
        .rst     (rst),
        .scl_i   (scl_m),
        .sda_i   (sda_line),
        .chip_en (chip_en),
        .wr_lock (wr_lock),
        .sda_oe  (sda_oe)
    );

    int n_chk  = 0;
    int n_fail = 0;
    int quiet_viol = 0;
    bit quiet_win = 1'b0;
    bit done = 1'b0;

    // reference model state
    logic [7:0] mem_m [int];
    int         ptr = 0;
    logic [7:0] pbuf [32];
    bit         pval [32];

    // every-clock comparison: during an expected silent window the line is never pulled
    always @(negedge clk) begin
        if (quiet_win && sda_oe) quiet_viol++;
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic clk_bit(input logic b, output logic s);
        wait_clk(H); sda_m = b;
        wait_clk(H); scl_m = 1'b1;
        wait_clk(H); s = sda_line;
        wait_clk(H); scl_m = 1'b0;
    endtask

    task automatic start_c();
        wait_clk(H); sda_m = 1'b1;
        wait_clk(H); scl_m = 1'b1;
        wait_clk(H); sda_m = 1'b0;
        wait_clk(H); scl_m = 1'b0;
    endtask

    task automatic stop_c();
        wait_clk(H); sda_m = 1'b0;
        wait_clk(H); scl_m = 1'b1;
        wait_clk(H); sda_m = 1'b1;
        wait_clk(2*H);
    endtask

    task automatic send_byte(input logic [7:0] b, input logic exp_ack, input string req);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
        clk_bit(1'b1, s);
        check(req, "ack", {31'd0, ~s}, {31'd0, exp_ack});
    endtask

    task automatic recv_byte(input logic [7:0] exp, input logic m_ack, input string req);
        logic s;
        logic [7:0] v;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, s);
            v[i] = s;
        end
        check(req, "read data", {24'd0, v}, {24'd0, exp});
        clk_bit(~m_ack, s);
    endtask

    task automatic read_seq(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            recv_byte(mem_m[ptr], (i != n - 1), req);
            ptr = (ptr + 1) & 8191;
        end
    endtask

    task automatic do_write(input logic [15:0] a16, input logic [7:0] dq[$],
                            input logic lock, input string req);
        int npend = 0;
        int base;
        start_c();
        send_byte({DEVT, CE, 1'b0}, 1'b1, "R3");
        send_byte(a16[15:8], 1'b1, "R4");
        send_byte(a16[7:0], 1'b1, "R4");
        ptr = int'(a16) & 8191;
        foreach (dq[i]) begin
            send_byte(dq[i], ~lock, req);
            if (lock) break;
            pbuf[ptr % 32] = dq[i];
            pval[ptr % 32] = 1'b1;
            ptr = (ptr & ~31) | ((ptr + 1) & 31);
            npend++;
        end
        stop_c();
        if (npend > 0) begin
            base = ptr & ~31;
            for (int k = 0; k < 32; k++) begin
                if (pval[k]) mem_m[base + k] = pbuf[k];
                pval[k] = 1'b0;
            end
            quiet_viol = 0;
            quiet_win  = 1'b1;
            start_c();
            send_byte({DEVT, CE, 1'b0}, 1'b0, "R6");
            stop_c();
            wait_clk(WC + 40);
            quiet_win = 1'b0;
            check("R6", "pulls during programming", quiet_viol, 0);
        end
    endtask

    task automatic do_rand_read(input logic [15:0] a16, input int n, input string req);
        start_c();
        send_byte({DEVT, CE, 1'b0}, 1'b1, "R9");
        send_byte(a16[15:8], 1'b1, "R9");
        send_byte(a16[7:0], 1'b1, "R9");
        ptr = int'(a16) & 8191;
        start_c();
        send_byte({DEVT, CE, 1'b1}, 1'b1, "R9");
        read_seq(n, req);
        stop_c();
    endtask

    task automatic do_cur_read(input int n, input string req);
        start_c();
        send_byte({DEVT, CE, 1'b1}, 1'b1, req);
        read_seq(n, req);
        stop_c();
    endtask

    initial begin
        logic [7:0] q[$];
        for (int k = 0; k < 32; k++) pval[k] = 1'b0;
        wait_clk(4);
        check("R1", "sda_oe in reset", {31'd0, sda_oe}, 32'd0);
        rst = 1'b0;
        wait_clk(4);
        check("R1", "sda_oe after reset", {31'd0, sda_oe}, 32'd0);

        // R5/R6: single byte write, then random read through repeated START (R9)
        q = {8'h5A};
        do_write(16'h0123, q, 1'b0, "R5");
        do_rand_read(16'h0123, 1, "R9");
        check("R2", "line released after stop", {31'd0, sda_oe}, 32'd0);

        // R5: 34-byte burst starting two bytes before page end wraps and overwrites
        q = {};
        for (int i = 0; i < 34; i++) q.push_back(8'hA0 + 8'(i));
        do_write(16'h005E, q, 1'b0, "R5");
        do_rand_read(16'h0040, 32, "R10");

        // R3: wrong chip enable and wrong type code are not acknowledged
        start_c();
        send_byte({DEVT, 3'b001, 1'b1}, 1'b0, "R3");
        stop_c();
        start_c();
        send_byte({4'b1011, CE, 1'b0}, 1'b0, "R3");
        stop_c();

        // R7: lock refuses data, nothing written, no programming period (R9 current read)
        wr_lock = 1'b1;
        q = {8'hFF};
        do_write(16'h0123, q, 1'b1, "R7");
        wr_lock = 1'b0;
        do_cur_read(1, "R7");

        // R8: address-only write sets the pointer without a programming period
        start_c();
        send_byte({DEVT, CE, 1'b0}, 1'b1, "R8");
        send_byte(8'h00, 1'b1, "R8");
        send_byte(8'h50, 1'b1, "R8");
        ptr = 16'h0050;
        stop_c();
        do_cur_read(3, "R8");

        // R4: high address bits ignored; R10: rollover from 8191 to 0
        q = {8'h77};
        do_write(16'hFFFF, q, 1'b0, "R4");
        q = {8'h11};
        do_write(16'h0000, q, 1'b0, "R4");
        do_rand_read(16'h1FFF, 2, "R10");
        do_cur_read(1, "R9");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog run did not complete actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

endmodule